// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is a byte-oriented, full-duplex SPI master meant to sit inside a microcontroller-style peripheral. Software starts a transfer just by writing a byte to the data buffer port. The engine then drives the serial clock and serial data out with the most significant bit first. At the same time it captures serial data in, and when the last bit is done it hands the received byte back through the buffer. A completion flag and a buffer-full flag tell software that the byte is ready.

Several static controls set the waveform:

- The polarity control sets the idle level of the serial clock.
- The edge control sets whether output data is already valid before the first clock edge of a bit, or changes together with it.
- The sample control sets whether input data is captured in the middle or at the end of each bit.
- A two-bit rate select chooses the bit period. Three settings divide the system clock by fixed ratios. The fourth counts pulses of an external timer tick.

When the data-out enable is low, the output is released and reception still runs at the chosen rate. This lets the engine passively monitor a line.

Top module: `spi_master_engine`

## Requirements
- R1: A write (`wr_en` high) while idle starts a transfer at once. `busy` is high from the next cycle, and the first half-bit begins in that cycle.
- R2: Data leaves on `sdo` most significant bit first. Each bit is held for its full bit time, which is two half-bits.
- R3: The half-bit length is set by `rate_sel`. Code 0 gives DIV_A/2 system clocks, code 1 gives DIV_B/2, and code 2 gives DIV_C/2 (defaults 2, 8 and 32). Code 3 gives one half-bit per `timer_tick` pulse.
- R4: While idle, and again after the byte ends, `sck` equals `clk_pol`.
- R5: With `edge_sel` = 1, `sck` sits at idle level in the first half of each bit and at active level in the second. With `edge_sel` = 0 this is reversed, so `sdo` changes together with the first edge of each bit.
- R6: With `smp_end` = 0, `sdi` is captured at the end of the first half of each bit. With `smp_end` = 1, it is captured at the end of the second half.
- R7: 16 half-bits after the start edge, `busy` falls. In that same cycle `rd_data` shows the received byte and both `irq_flag` and `buf_full` are set.
- R8: `irq_flag` stays set until a `clr_irq` pulse. `buf_full` stays set until an `rd_en` pulse. Neither pulse affects the other flag.
- R9: A write while `busy` is high, including the final cycle of a byte, is ignored: the byte on the line is unchanged. The write sets the sticky `wcol` flag, which only `clr_wcol` clears.
- R10: With `sdo_en` = 0, `sdo_oe` and `sdo` are low, and the byte is still received and completed as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_pol | input | 1 | Idle level of sck |
| edge_sel | input | 1 | 1: data valid before first edge of bit; 0: data changes on it |
| smp_end | input | 1 | 0: capture mid-bit; 1: capture at end of bit |
| rate_sel | input | 2 | Bit-rate code (see R3) |
| timer_tick | input | 1 | External half-bit pulse used by rate code 3 |
| sdo_en | input | 1 | Enables the data output driver |
| wr_en | input | 1 | Buffer write strobe; starts a transfer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Buffer read strobe; clears buf_full |
| clr_irq | input | 1 | Clears irq_flag |
| clr_wcol | input | 1 | Clears wcol |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| rd_data | output | DATA_W | Last received byte |
| irq_flag | output | 1 | Completion flag |
| buf_full | output | 1 | Received byte not yet read |
| wcol | output | 1 | Write-collision flag |
| busy | output | 1 | Transfer in progress |

## Verification
The bench drives `sdi` with a different value in each half of every bit, so the received byte shows which half was sampled. A sample-phase mix-up therefore returns the wrong pattern. Every cycle of each byte is compared against the expected `sck` and `sdo` for each rate, polarity and edge setting. This exposes an off-by-one half-bit count, a wrong divider, an inverted clock phase, or LSB-first shifting as a mismatch at a known cycle. A mid-byte write is checked to corrupt neither `sdo` nor the received byte, and to leave `wcol` set. The timer rate is checked to take exactly sixteen ticks. Monitor mode is checked to keep the line quiet while still completing the byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   typedef enum logic [1:0] {
      RATE_DIV_A = 2'd0,
      RATE_DIV_B = 2'd1,
      RATE_DIV_C = 2'd2,
      RATE_TIMER = 2'd3
   } rate_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
   import spi_eng_pkg::*;
#(
   parameter int DIV_A = 4,
   parameter int DIV_B = 16,
   parameter int DIV_C = 64
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  rate_e rate,
   input  logic  timer_tick,
   output logic  half_tick
);
   localparam int HALF_A = DIV_A / 2;
   localparam int HALF_B = DIV_B / 2;
   localparam int HALF_C = DIV_C / 2;
   localparam int CW     = (HALF_C > 1) ? $clog2(HALF_C) : 1;

   generate
      if (DIV_A < 4 || (DIV_A % 2) != 0 || (DIV_B % 2) != 0 || (DIV_C % 2) != 0)
         begin : g_bad_div
            $error("spi_rate_gen: dividers must be even and at least 4");
         end
      if (DIV_B <= DIV_A || DIV_C <= DIV_B) begin : g_bad_order
         $error("spi_rate_gen: dividers must increase A < B < C");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      case (rate)
         RATE_DIV_A: lim = CW'(HALF_A - 1);
         RATE_DIV_B: lim = CW'(HALF_B - 1);
         default:    lim = CW'(HALF_C - 1);
      endcase
   end

   assign half_tick = run & ((rate == RATE_TIMER) ? timer_tick : (cnt == lim));

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || half_tick) cnt <= '0;
      else if (rate != RATE_TIMER) cnt <= cnt + 1'b1;
   end

   // R3: the divider count never passes the selected half-bit limit
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rate != RATE_TIMER) |-> (cnt <= lim));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] load,
   input  logic          half_tick,
   input  logic          smp_end,
   input  logic          sdi,
   output logic          busy,
   output logic          done,
   output logic          phase,
   output logic          sr_msb,
   output logic [DW-1:0] rx_next
);
   localparam int LAST = 2 * DW - 1;
   localparam int HC_W = $clog2(2 * DW);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("spi_shift_core: DW must be at least 2");
      end
   endgenerate

   logic [DW-1:0]   sr;
   logic [HC_W-1:0] hcnt;
   logic            mid_q;

   assign phase   = hcnt[0];
   assign sr_msb  = sr[DW-1];
   assign rx_next = {sr[DW-2:0], smp_end ? sdi : mid_q};
   assign done    = busy & half_tick & (hcnt == HC_W'(LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         hcnt  <= '0;
         sr    <= '0;
         mid_q <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         hcnt <= '0;
         sr   <= load;
      end else if (busy && half_tick) begin
         if (!hcnt[0]) mid_q <= sdi;
         else          sr    <= rx_next;
         hcnt <= hcnt + 1'b1;
         if (hcnt == HC_W'(LAST)) busy <= 1'b0;
      end
   end

   // R1: a start opens a transfer at half-bit zero
   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && hcnt == '0));
   // R2: shift register only moves on a half-bit boundary
   p_sr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !half_tick && !start) |=> $stable(sr));
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
   import spi_eng_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_A  = 4,
   parameter int DIV_B  = 16,
   parameter int DIV_C  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_pol,
   input  logic              edge_sel,
   input  logic              smp_end,
   input  logic [1:0]        rate_sel,
   input  logic              timer_tick,
   input  logic              sdo_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              clr_irq,
   input  logic              clr_wcol,
   input  logic              sdi,
   output logic              sck,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_flag,
   output logic              buf_full,
   output logic              wcol,
   output logic              busy
);
   logic              start;
   logic              half_tick;
   logic              done;
   logic              phase;
   logic              sr_msb;
   logic [DATA_W-1:0] rx_next;
   logic [DATA_W-1:0] buf_q;

   assign start = wr_en & ~busy;

   spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .rate       (rate_e'(rate_sel)),
      .timer_tick (timer_tick),
      .half_tick  (half_tick)
   );

   spi_shift_core #(.DW(DATA_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .load      (wr_data),
      .half_tick (half_tick),
      .smp_end   (smp_end),
      .sdi       (sdi),
      .busy      (busy),
      .done      (done),
      .phase     (phase),
      .sr_msb    (sr_msb),
      .rx_next   (rx_next)
   );

   assign sck     = clk_pol ^ (busy & (edge_sel ? phase : ~phase));
   assign sdo_oe  = sdo_en;
   assign sdo     = sdo_en & sr_msb;
   assign rd_data = buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q    <= '0;
         irq_flag <= 1'b0;
         buf_full <= 1'b0;
         wcol     <= 1'b0;
      end else begin
         if (done) buf_q <= rx_next;
         if (done)         irq_flag <= 1'b1;
         else if (clr_irq) irq_flag <= 1'b0;
         if (done)         buf_full <= 1'b1;
         else if (rd_en)   buf_full <= 1'b0;
         if (wr_en && busy) wcol <= 1'b1;
         else if (clr_wcol) wcol <= 1'b0;
      end
   end

   // R7: completion raises both flags by the time busy is seen low
   p_done_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (irq_flag && buf_full));
   // R8: completion flag is sticky
   p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !clr_irq) |=> irq_flag);
   // R9: write during a byte flags a collision
   p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> wcol);
endmodule

// File: tb/tb_spi_master_engine.sv
`timescale 1ns/1ps
module tb_spi_master_engine;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       clk_pol, edge_sel, smp_end, timer_tick, sdo_en;
   logic [1:0] rate_sel;
   logic       wr_en, rd_en, clr_irq, clr_wcol, sdi;
   logic [7:0] wr_data;
   logic       sck, sdo, sdo_oe, irq_flag, buf_full, wcol, busy;
   logic [7:0] rd_data;

   int vectors = 0;
   int fails   = 0;
   bit ended   = 0;

   always #4 clk = ~clk;

   spi_master_engine dut (
      .clk(clk), .rst_n(rst_n), .clk_pol(clk_pol), .edge_sel(edge_sel),
      .smp_end(smp_end), .rate_sel(rate_sel), .timer_tick(timer_tick),
      .sdo_en(sdo_en), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .clr_irq(clr_irq), .clr_wcol(clr_wcol), .sdi(sdi), .sck(sck),
      .sdo(sdo), .sdo_oe(sdo_oe), .rd_data(rd_data), .irq_flag(irq_flag),
      .buf_full(buf_full), .wcol(wcol), .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cfg(input logic pol, input logic edg, input logic smp,
                      input logic [1:0] rate, input logic en);
      clk_pol = pol; edge_sel = edg; smp_end = smp; rate_sel = rate; sdo_en = en;
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   // Fixed-rate byte: per-cycle waveform checks; sdi = a in first half, b in second
   task automatic run_fixed(input logic [7:0] tx, input logic [7:0] a,
                            input logic [7:0] b, input int half, input int collide_at);
      wr_data = tx;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      for (int c = 0; c < 16 * half; c++) begin
         int h;
         int bi;
         h  = c / half;
         bi = 7 - h / 2;
         chk("R1 busy during byte", busy, 1);
         chk("R5 sck phase", sck, clk_pol ^ (edge_sel ? h % 2 : 1 - h % 2));
         chk("R2 sdo msb-first", sdo, sdo_en ? tx[bi] : 1'b0);
         if (!sdo_en) chk("R10 sdo_oe low", sdo_oe, 0);
         sdi = (h % 2 == 0) ? a[bi] : b[bi];
         if (c == collide_at) begin
            wr_data = ~tx;
            wr_en   = 1'b1;
         end
         @(negedge clk);
         wr_en = 1'b0;
         if (c == collide_at) chk("R9 wcol set", wcol, 1);
      end
      chk("R7 busy fell", busy, 0);
      chk("R7 irq set", irq_flag, 1);
      chk("R7 buf_full set", buf_full, 1);
      chk("R6 sample phase rx", rd_data, smp_end ? b : a);
      chk("R4 idle level after byte", sck, clk_pol);
   endtask

   task automatic clear_flags();
      pulse(clr_irq);
      pulse(rd_en);
      pulse(clr_wcol);
   endtask

   task automatic t_reset();
      chk("R4 reset sck idle", sck, 0);
      chk("R7 reset busy", busy, 0);
      chk("R8 reset irq", irq_flag, 0);
      chk("R8 reset buf_full", buf_full, 0);
      chk("R9 reset wcol", wcol, 0);
      cfg(1, 1, 0, 2'd0, 1);
      @(negedge clk);
      chk("R4 idle follows pol", sck, 1);
   endtask

   task automatic t_rates();
      cfg(0, 1, 0, 2'd0, 1);
      run_fixed(8'hA5, 8'h3C, 8'hC3, 2, -1);
      clear_flags();
      cfg(1, 0, 1, 2'd1, 1);
      run_fixed(8'h5A, 8'h0F, 8'h96, 8, -1);
      clear_flags();
      cfg(0, 0, 1, 2'd2, 1);
      run_fixed(8'h81, 8'hFF, 8'h42, 32, -1);
      clear_flags();
      cfg(1, 1, 0, 2'd0, 1);
      run_fixed(8'h6E, 8'h71, 8'h00, 2, -1);
      run_fixed(8'h93, 8'hE8, 8'h17, 2, -1); // R1 back-to-back start
      clear_flags();
   endtask

   task automatic t_timer();
      int ticks;
      int cyc;
      logic [7:0] a;
      logic [7:0] b;
      ticks = 0;
      cyc = 0;
      a = 8'hB4;
      b = 8'h2D;
      cfg(0, 1, 1, 2'd3, 1);
      wr_data = 8'hC6;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      while (busy && cyc < 2000) begin
         int bi;
         bi = 7 - ticks / 2;
         if (ticks < 16) begin
            chk("R3 timer sck", sck, ticks % 2);
            chk("R2 timer sdo", sdo, wr_data[bi]);
            sdi = (ticks % 2 == 0) ? a[bi] : b[bi];
         end
         timer_tick = (cyc % 3 == 2);
         if (timer_tick) ticks++;
         cyc++;
         @(negedge clk);
         timer_tick = 1'b0;
      end
      chk("R3 sixteen ticks per byte", ticks, 16);
      chk("R6 timer rx end sample", rd_data, b);
      clear_flags();
   endtask

   task automatic t_collision();
      cfg(0, 1, 0, 2'd0, 1);
      run_fixed(8'hA5, 8'h3C, 8'h3C, 2, 10);
      chk("R9 wcol sticky", wcol, 1);
      repeat (3) @(negedge clk);
      chk("R9 wcol still set", wcol, 1);
      pulse(clr_wcol);
      chk("R9 wcol cleared", wcol, 0);
      clear_flags();
   endtask

   task automatic t_flags();
      cfg(0, 0, 0, 2'd0, 1);
      run_fixed(8'h11, 8'h22, 8'h44, 2, -1);
      repeat (5) @(negedge clk);
      chk("R8 irq sticky", irq_flag, 1);
      pulse(rd_en);
      chk("R8 rd clears full", buf_full, 0);
      chk("R8 rd leaves irq", irq_flag, 1);
      pulse(clr_irq);
      chk("R8 clr_irq clears irq", irq_flag, 0);
   endtask

   task automatic t_monitor();
      cfg(0, 1, 1, 2'd1, 0);
      run_fixed(8'hFF, 8'h55, 8'hAA, 8, -1);
      chk("R10 monitor oe", sdo_oe, 0);
      clear_flags();
   endtask

   initial begin
      rst_n = 1'b0;
      cfg(0, 1, 0, 2'd0, 1);
      timer_tick = 0; wr_en = 0; rd_en = 0; clr_irq = 0; clr_wcol = 0;
      sdi = 0; wr_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rates();
      t_timer();
      t_collision();
      t_flags();
      t_monitor();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         vectors++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule